// File: doc/BRIEF.md
# Per-Channel Signaling Frame Aligner

This block lines up the ABCD signaling nibbles of two or three remote channels whose frames reach the local PCM frame sync with different delays. Each channel has its own 4-bit frame-delay setting. The block counts local PCM frame pulses from the local frame-0 pulse and finds, for each channel, the frame where that channel's own frame 0 appears. At that frame it captures the channel's signaling nibble into a held output register.

A setting of N gives a delay of N+1 frames, so settings 0 to 15 cover 1 to 16 frames. A one-frame delay means frame 0 falls in the first payload block after local frame 0. Logic outside the block measures the remote sync phase and computes each setting as truncate(phase_in_PCM_bits / PCM_bits_per_frame) - 1. Grooming applies only in a two- or three-channel E1 point-to-multipoint setup.

When the enable pin is low, every channel's signaling goes straight to its output with no added delay. The signaling paths are level-held control data rather than a packet stream, so the pins carry no valid/ready handshake. `sig_upd` is a one-cycle marker and does not wait for an acknowledge.

Top module: `sig_frame_align`

## Requirements
- R1: After reset with `align_en` high, every `sig_out` nibble is 0, every `sig_upd` bit is 0 and no channel is armed.
- R2: While `align_en` is low, `sig_out` equals `sig_in` in the same cycle, `sig_upd` stays 0, and every channel is disarmed.
- R3: A frame is a cycle with `frame_tick` high. A frame with `frame_tick` and `mf_start` both high arms a channel and loads its count to 0. A channel with setting N captures its `sig_in` nibble at the (N+1)-th later frame. The captured nibble shows on `sig_out` from the next cycle.
- R4: A setting of 0 captures at the first frame after local frame 0.
- R5: A setting of 15 captures at the sixteenth frame after local frame 0.
- R6: Between captures, `sig_out` holds its value whatever `sig_in` does.
- R7: Channels count independently, each against its own setting in field [4c+3:4c] of `dly_set` and `sig_in`.
- R8: The setting is sampled at frame 0. Changing `dly_set` after that has no effect until the next frame 0.
- R9: A frame 0 that arrives before a channel captures restarts that channel's count from 0.
- R10: If a capture frame is also a frame 0, the capture happens and the channel re-arms with its count at 0.
- R11: `sig_upd[c]` is high for exactly the one cycle after channel c captures.
- R12: Cycles with `frame_tick` low do not advance any count.
- R13: `mf_start` without `frame_tick` is ignored. It neither arms a channel nor restarts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per local PCM frame |
| mf_start | input | 1 | Marks local frame 0; valid only with `frame_tick` |
| align_en | input | 1 | Enables per-channel alignment; low gives pass-through |
| dly_set | input | NCH*4 | Per-channel frame-delay setting (setting+1 frames) |
| sig_in | input | NCH*4 | Per-channel signaling nibbles |
| sig_out | output | NCH*4 | Aligned signaling nibbles per channel |
| sig_upd | output | NCH | Per-channel capture marker, one cycle after capture |

## Verification
A counter that is off by one, or that advances on idle cycles, captures the nibble from the wrong frame. That wrong nibble reaches `sig_out`, and `sig_upd` pulses in the wrong frame, one cycle after the faulty frame pulse. A delay that is latched late, or an armed flag that is not cleared, shows up as a missing, extra or repeated `sig_upd` within the next sixteen frames. Each frame gives new nibbles per channel, so any slip in timing shows up directly as a wrong value on `sig_out`.

// File: rtl/sig_align_pkg.sv
package sig_align_pkg;
  typedef enum logic {CH_IDLE = 1'b0, CH_ARMED = 1'b1} ch_state_t;
endpackage

// File: rtl/sa_frame_counter.sv
module sa_frame_counter
  import sig_align_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             hit
);
  ch_state_t        st;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] dly_l;

  assign hit = en && tick && (st == CH_ARMED) && (cnt == dly_l);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= CH_IDLE;
      cnt   <= '0;
      dly_l <= '0;
    end else if (!en) begin
      st  <= CH_IDLE;
      cnt <= '0;
    end else if (tick) begin
      if (start) begin
        st    <= CH_ARMED;
        cnt   <= '0;
        dly_l <= dly;
      end else if (hit) begin
        st <= CH_IDLE;
      end else if (st == CH_ARMED) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_ARMED) |-> (cnt <= dly_l)); // R3
  AST_DISABLE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == CH_IDLE)); // R2
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt)); // R12
  AST_SETTING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && tick && start) |=> $stable(dly_l)); // R8
  AST_HIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !start) |=> (st == CH_IDLE)); // R11
endmodule

// File: rtl/sa_sig_hold.sv
module sa_sig_hold #(
  parameter int SIG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [SIG_W-1:0] d,
  output logic [SIG_W-1:0] q,
  output logic             upd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      upd <= 1'b0;
    end else begin
      upd <= cap;
      if (cap) q <= d;
    end
  end

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (q == $past(d))); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(q)); // R6
  AST_UPD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(cap)); // R11
endmodule

// File: rtl/sig_frame_align.sv
module sig_frame_align #(
  parameter int NCH   = 3,
  parameter int DLY_W = 4,
  parameter int SIG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic                 mf_start,
  input  logic                 align_en,
  input  logic [NCH*DLY_W-1:0] dly_set,
  input  logic [NCH*SIG_W-1:0] sig_in,
  output logic [NCH*SIG_W-1:0] sig_out,
  output logic [NCH-1:0]       sig_upd
);
  localparam int SIG_BITS = NCH * SIG_W;

  logic [NCH-1:0]      hit;
  logic [SIG_BITS-1:0] held;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sa_frame_counter #(.DLY_W(DLY_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (align_en),
      .tick  (frame_tick),
      .start (mf_start),
      .dly   (dly_set[c*DLY_W +: DLY_W]),
      .hit   (hit[c])
    );
    sa_sig_hold #(.SIG_W(SIG_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (hit[c]),
      .d     (sig_in[c*SIG_W +: SIG_W]),
      .q     (held[c*SIG_W +: SIG_W]),
      .upd   (sig_upd[c])
    );
  end

  assign sig_out = align_en ? held : sig_in;

  AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en |-> (hit == '0)); // R2
  AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |-> (hit == '0)); // R13
endmodule

// File: tb/sig_frame_align_test.sv
module sig_frame_align_test;
  localparam int NCH = 3;
  logic clk = 0, rst_n = 0, frame_tick = 0, mf_start = 0, align_en = 1;
  logic [NCH*4-1:0] dly_set = '0, sig_in = '0;
  logic [NCH*4-1:0] sig_out;
  logic [NCH-1:0]   sig_upd;
  int n_chk = 0, n_bad = 0;
  bit m_armed [NCH];
  logic [3:0] m_cnt [NCH], m_dly [NCH], m_out [NCH];
  logic       m_upd [NCH];

  always #4 clk = ~clk;

  sig_frame_align #(.NCH(NCH)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < NCH; c++) begin
      logic [3:0] e = align_en ? m_out[c] : sig_in[c*4 +: 4];
      chk(sig_out[c*4 +: 4] == e, tag, sig_out[c*4 +: 4], e);
      chk(sig_upd[c] == (align_en && m_upd[c]), {tag, " R11"}, sig_upd[c], m_upd[c]);
    end
  endtask

  // one frame pulse; model follows the requirements
  task automatic frame(input bit f0, input string tag);
    @(negedge clk);
    frame_tick = 1; mf_start = f0;
    for (int c = 0; c < NCH; c++) begin
      bit h = align_en && m_armed[c] && (m_cnt[c] == m_dly[c]);
      m_upd[c] = h;
      if (h) m_out[c] = sig_in[c*4 +: 4];
      if (!align_en) m_armed[c] = 0;
      else if (f0) begin m_armed[c] = 1; m_cnt[c] = 0; m_dly[c] = dly_set[c*4 +: 4]; end
      else if (h) m_armed[c] = 0;
      else if (m_armed[c]) m_cnt[c] = m_cnt[c] + 1;
    end
    @(negedge clk);
    frame_tick = 0; mf_start = 0;
    compare(tag);
    for (int c = 0; c < NCH; c++) m_upd[c] = 0;
  endtask

  task automatic idle(input int n, input string tag);
    repeat (n) @(negedge clk);
    compare(tag);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCH; c++) begin m_armed[c] = 0; m_cnt[c] = 0; m_dly[c] = 0; m_out[c] = 0; m_upd[c] = 0; end
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    compare("R1 reset");
    frame(0, "R1 unarmed");
  endtask

  task automatic t_pass;
    align_en = 0; sig_in = 12'h5A3; #1;
    compare("R2 passthru");
    frame(1, "R2 no arm");
    sig_in = 12'h1C7; #1;
    compare("R2 follow");
    frame(0, "R2 no capture");
    align_en = 1;
    idle(1, "R2 restore");
  endtask

  task automatic t_delays;
    dly_set = {4'd15, 4'd3, 4'd0};
    sig_in = 12'h999;
    frame(1, "R3 frame0");
    for (int k = 1; k <= 17; k++) begin
      sig_in = {4'(k + 8), 4'(k + 4), 4'(k)};
      frame(0, k == 1 ? "R4 dly0" : k == 4 ? "R3 R7 dly3" : k == 16 ? "R5 dly15" : "R6 hold");
      sig_in = ~sig_in;
      idle(2, "R12 R6 idle");
    end
  endtask

  task automatic t_latch;
    dly_set = {4'd1, 4'd1, 4'd2};
    frame(1, "R8 frame0");
    dly_set = '0;
    sig_in = 12'h321; frame(0, "R8 pulse1");
    sig_in = 12'h654; frame(0, "R8 pulse2");
    sig_in = 12'h987; frame(0, "R8 pulse3");
  endtask

  task automatic t_restart;
    dly_set = {4'd2, 4'd2, 4'd3};
    frame(1, "R9 frame0");
    sig_in = 12'hABC; frame(0, "R9 p1");
    sig_in = 12'hBCD; frame(0, "R9 p2");
    sig_in = 12'hCDE; frame(1, "R9 restart");
    for (int k = 0; k < 4; k++) begin
      sig_in = 12'(12'h111 * (k + 2)); frame(0, "R9 after");
    end
  endtask

  task automatic t_coincide;
    dly_set = {4'd1, 4'd0, 4'd1};
    frame(1, "R10 frame0");
    sig_in = 12'h246; frame(0, "R10 p1");
    sig_in = 12'h8AC; frame(1, "R10 hit+f0");
    sig_in = 12'h135; frame(0, "R10 p1b");
    sig_in = 12'h79B; frame(0, "R10 p2b");
  endtask

  task automatic t_f0_alone;
    dly_set = '0;
    @(negedge clk); mf_start = 1; @(negedge clk); mf_start = 0;
    sig_in = 12'hF0F; frame(0, "R13 ignored");
    idle(1, "R13 held");
  endtask

  initial begin
    fork
      begin
        t_reset; t_pass; t_delays; t_latch; t_restart; t_coincide; t_f0_alone;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule